// File: doc/BRIEF.md
# Command Frame Serializer with CRC-4

This block turns one request from a link sequencer into a serial command frame. It then shifts the frame out on a two-wire link made of a clock line and a data line. Four kinds of frame are supported:

- absolute-address read of 1, 2 or 4 bytes;
- absolute-address write of 1, 2 or 4 bytes;
- data-poll;
- terminate.

The sequencer pulses `start_i` with the slave id, the command, the address, the size code and the write data. The block latches the frame and drives it out at one bit per link clock period.

A frame on the wire has three parts in this order:

- a leading start bit;
- the message bits, most significant first;
- a 4-bit CRC that covers the start bit and every message bit.

The line is active low. While a frame is in flight the block raises the output-enable and level-translator direction controls. When the last CRC bit has been sent it pulses `done_o`, releases both controls and lets the data line rest high. Receiving the response and deciding on retries belong to other blocks.

Top module: `cmd_frame_ser`

## Requirements
- R1: Out of reset and whenever no frame is in flight, `link_data_o` and `link_clk_o` are 1, and `busy_o`, `data_oe_o`, `trans_dir_o` and `done_o` are 0.
- R2: The line is active low. A logical 1 is driven as `link_data_o`=0 and a logical 0 as 1. The first bit of every frame is a start bit of logical 1. `data_oe_o` and `trans_dir_o` are 1 for the whole frame.
- R3: `cmd_i`=00 (read) sends these message fields, most significant bit first:
  - slave id (2 bits);
  - opcode 100;
  - read flag 1;
  - address field (21 bits);
  - size flag (1 bit).
- R4: `size_i` selects the transfer size, which sets the address field and the size flag:
  - 00 = 1 byte: address unchanged, size flag 0;
  - 01 = 2 bytes: address bit 0 forced to 0, size flag 1;
  - 10 or 11 = 4 bytes: address bits [1:0] forced to 01, size flag 1.
- R5: `cmd_i`=01 (write) sends the same fields as R3 with read flag 0. The data bytes follow, starting with `wdata_i[7:0]`, then `[15:8]` and so on, as many as the size code selects, each byte most significant bit first.
- R6: `cmd_i`=10 (data-poll) sends the slave id followed by opcode 010.
- R7: `cmd_i`=11 (terminate) sends the slave id followed by opcode 111111.
- R8: Four CRC bits follow the message, most significant first. The CRC uses polynomial x^4+x+1 and starts from 0. It is updated one bit at a time, most significant first, over the start bit and then every message bit.
- R9: Each bit occupies one link clock period of 2*`HALF_CYCLES` clock cycles: a low half, then a high half. `link_data_o` changes only while `link_clk_o` is low and is stable at each rising edge. A frame of N bits keeps `busy_o` high for N*2*`HALF_CYCLES` cycles.
- R10: `done_o` is high for exactly one cycle, in the first cycle after the last CRC bit. In that cycle the data line is already back at 1 and the output controls are released.
- R11: `start_i` has no effect while `busy_o` is 1. The frame in flight is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled while idle |
| cmd_i | input | 2 | 00 read, 01 write, 10 data-poll, 11 terminate |
| slave_id_i | input | 2 | Target slave id |
| addr_i | input | 21 | Byte address |
| size_i | input | 2 | 00 one byte, 01 two bytes, 1x four bytes |
| wdata_i | input | 32 | Write data, byte 0 in bits [7:0] |
| busy_o | output | 1 | Frame in flight |
| done_o | output | 1 | One-cycle pulse after the last CRC bit |
| link_clk_o | output | 1 | Link clock, rests high |
| link_data_o | output | 1 | Link data, active low, rests high |
| data_oe_o | output | 1 | Data pin output enable |
| trans_dir_o | output | 1 | Level-translator direction, high while driving |

## Verification
The checker watches the line discipline on every cycle:

- idle levels on both link wires;
- a start bit driven low as the frame opens;
- data moving only in the low half of the link clock and held across each rising edge;
- a single-cycle `done_o` that comes only as the frame closes with the line high.

Only the bench scenarios can show that the bits on the wire are the right ones. They cover the field order of each command, the address rewriting for each size code, the write byte order and the CRC value. They also cover the exact frame length in cycles and that a mid-frame `start_i` leaves the frame and the following idle period untouched. To check these, the bench captures the line at each rising link clock edge and compares it with a frame it builds on its own.

// File: rtl/cfs_pkg.sv
`timescale 1ns/1ps
package cfs_pkg;
  localparam int ID_W      = 2;
  localparam int ADDR_W    = 21;
  localparam int OPC_W     = 3;
  localparam int MAX_BYTES = 4;
  localparam int DATA_W    = 8 * MAX_BYTES;
  localparam int CRC_W     = 4;
  localparam int HDR_W     = ID_W + OPC_W + 1 + ADDR_W + 1;
  localparam int MSG_W     = HDR_W + DATA_W;
  localparam int LEN_W     = $clog2(MSG_W + 1);
  localparam int CCNT_W    = $clog2(CRC_W);

  localparam logic [OPC_W-1:0] OPC_ABS   = 3'b100;
  localparam logic [OPC_W-1:0] OPC_POLL  = 3'b010;
  localparam logic [5:0]       OPC_TERM  = 6'b111111;
  localparam logic [CRC_W-1:0] CRC_POLY  = 4'b0011;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_POLL  = 2'b10,
    CMD_TERM  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MSG  = 2'd1,
    ST_CRC  = 2'd2
  } state_e;

  function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    crc4_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/cfs_frame_build.sv
`timescale 1ns/1ps
module cfs_frame_build import cfs_pkg::*; (
  input  cmd_e              cmd_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [MSG_W-1:0]  msg_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [DATA_W-1:0] swap;
  logic [ADDR_W-1:0] addr_enc;
  logic              size_flag;
  logic [HDR_W-1:0]  hdr;
  logic [MSG_W-1:0]  raw;
  int unsigned       nbytes;

  // byte 0 moves to the top so it leaves first
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_swap
    assign swap[DATA_W-1-8*b -: 8] = wdata_i[8*b +: 8];
  end

  always_comb begin
    addr_enc = addr_i;
    unique case (size_i)
      2'b00: begin nbytes = 1; size_flag = 1'b0; end
      2'b01: begin nbytes = 2; size_flag = 1'b1; addr_enc[0] = 1'b0; end
      default: begin nbytes = 4; size_flag = 1'b1; addr_enc[1:0] = 2'b01; end
    endcase
    hdr = {id_i, OPC_ABS, (cmd_i == CMD_READ), addr_enc, size_flag};
    unique case (cmd_i)
      CMD_READ: begin
        raw   = MSG_W'(hdr);
        len_o = LEN_W'(HDR_W);
      end
      CMD_WRITE: begin
        raw   = (MSG_W'(hdr) << (8 * nbytes)) | MSG_W'(swap >> (8 * (MAX_BYTES - nbytes)));
        len_o = LEN_W'(HDR_W + 8 * nbytes);
      end
      CMD_POLL: begin
        raw   = MSG_W'({id_i, OPC_POLL});
        len_o = LEN_W'(ID_W + OPC_W);
      end
      default: begin
        raw   = MSG_W'({id_i, OPC_TERM});
        len_o = LEN_W'(ID_W + 6);
      end
    endcase
    msg_o = raw << (MSG_W - int'(len_o));
  end
endmodule

// File: rtl/cfs_bit_timer.sv
`timescale 1ns/1ps
module cfs_bit_timer #(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bit_end_o,
  output logic link_clk_o
);
  localparam int PER  = 2 * HALF_CYCLES;
  localparam int PH_W = (PER > 2) ? $clog2(PER) : 1;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (!run_i || bit_end_o)         ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  assign bit_end_o  = run_i && (ph_q == PH_W'(PER - 1));
  assign link_clk_o = !run_i || (ph_q >= PH_W'(HALF_CYCLES));
endmodule

// File: rtl/cfs_crc4.sv
`timescale 1ns/1ps
module cfs_crc4 import cfs_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             bit_i,
  input  logic             shift_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] base;
  assign base = clr_i ? '0 : crc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= '0;
    else if (step_i)  crc_o <= crc4_step(base, bit_i);
    else if (shift_i) crc_o <= {crc_o[CRC_W-2:0], 1'b0};
    else if (clr_i)   crc_o <= '0;
  end
endmodule

// File: rtl/cmd_frame_ser.sv
`timescale 1ns/1ps
module cmd_frame_ser import cfs_pkg::*; #(
  parameter int HALF_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic [ID_W-1:0]   slave_id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              link_clk_o,
  output logic              link_data_o,
  output logic              data_oe_o,
  output logic              trans_dir_o
);
  state_e             state_q;
  logic [MSG_W-1:0]   shreg_q;
  logic [LEN_W-1:0]   left_q;
  logic [CCNT_W-1:0]  cleft_q;
  logic               line_q, done_q;
  logic [MSG_W-1:0]   msg;
  logic [LEN_W-1:0]   len;
  logic [CRC_W-1:0]   crc;
  logic               busy, bit_end, launch, msg_next, crc_first, crc_next;

  cfs_frame_build u_build (
    .cmd_i   (cmd_e'(cmd_i)),
    .id_i    (slave_id_i),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .wdata_i (wdata_i),
    .msg_o   (msg),
    .len_o   (len)
  );

  cfs_bit_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy),
    .bit_end_o  (bit_end),
    .link_clk_o (link_clk_o)
  );

  assign busy      = (state_q != ST_IDLE);
  assign launch    = (state_q == ST_IDLE) && start_i;
  assign msg_next  = bit_end && (state_q == ST_MSG) && (left_q != '0);
  assign crc_first = bit_end && (state_q == ST_MSG) && (left_q == '0);
  assign crc_next  = bit_end && (state_q == ST_CRC) && (cleft_q != '0);

  // start bit enters the CRC at launch, message bits as they go out
  cfs_crc4 u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (launch),
    .step_i  (launch || msg_next),
    .bit_i   (launch ? 1'b1 : shreg_q[MSG_W-1]),
    .shift_i (crc_first || crc_next),
    .crc_o   (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      cleft_q <= '0;
      line_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        state_q <= ST_MSG;
        shreg_q <= msg;
        left_q  <= len;
        line_q  <= 1'b0;
      end else if (msg_next) begin
        line_q  <= ~shreg_q[MSG_W-1];
        shreg_q <= shreg_q << 1;
        left_q  <= left_q - 1'b1;
      end else if (crc_first) begin
        state_q <= ST_CRC;
        line_q  <= ~crc[CRC_W-1];
        cleft_q <= CCNT_W'(CRC_W - 1);
      end else if (crc_next) begin
        line_q  <= ~crc[CRC_W-1];
        cleft_q <= cleft_q - 1'b1;
      end else if (bit_end && (state_q == ST_CRC)) begin
        state_q <= ST_IDLE;
        line_q  <= 1'b1;
        done_q  <= 1'b1;
      end
    end
  end

  assign busy_o      = busy;
  assign done_o      = done_q;
  assign link_data_o = line_q;
  assign data_oe_o   = busy;
  assign trans_dir_o = busy;
endmodule

// File: rtl/cmd_frame_ser_chk.sv
`timescale 1ns/1ps
module cmd_frame_ser_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic link_clk_o,
  input logic link_data_o,
  input logic data_oe_o,
  input logic trans_dir_o
);
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (link_data_o && link_clk_o && !data_oe_o && !trans_dir_o));

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!link_data_o && !link_clk_o && data_oe_o && trans_dir_o));

  p_data_on_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(link_data_o)) |-> !link_clk_o);

  p_hold_at_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_clk_o) |-> $stable(link_data_o));

  p_done_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && link_data_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind cmd_frame_ser cmd_frame_ser_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .link_clk_o  (link_clk_o),
  .link_data_o (link_data_o),
  .data_oe_o   (data_oe_o),
  .trans_dir_o (trans_dir_o)
);

// File: tb/sim_cmd_frame_ser.sv
`timescale 1ns/1ps
module sim_cmd_frame_ser;
  localparam int HALF = 2;
  localparam int NVEC = 9;
  // {cmd[58:57], id[56:55], addr[54:34], size[33:32], wdata[31:0]}
  localparam logic [58:0] VEC [NVEC] = '{
    {2'b00, 2'd1, 21'h012345, 2'd0, 32'h0000_0000},
    {2'b00, 2'd2, 21'h1FFFF3, 2'd1, 32'h0000_0000},
    {2'b00, 2'd3, 21'h0AAAAA, 2'd2, 32'h0000_0000},
    {2'b01, 2'd0, 21'h000007, 2'd0, 32'h0000_00A5},
    {2'b01, 2'd1, 21'h155555, 2'd1, 32'h0000_3C81},
    {2'b01, 2'd2, 21'h0F0F0E, 2'd2, 32'hDEAD_BEEF},
    {2'b10, 2'd3, 21'h1FFFFF, 2'd3, 32'hFFFF_FFFF},
    {2'b11, 2'd1, 21'h000000, 2'd0, 32'h1234_5678},
    {2'b01, 2'd3, 21'h010002, 2'd3, 32'h0123_4567}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cmd_i = '0;
  logic [1:0]  slave_id_i = '0;
  logic [20:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic busy_o, done_o, link_clk_o, link_data_o, data_oe_o, trans_dir_o;
  int tests = 0;
  int fails = 0;

  always #2 clk_i = ~clk_i;

  cmd_frame_ser #(.HALF_CYCLES(HALF)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] crc_upd(input logic [3:0] r, input logic b);
    logic [3:0] n;
    n = {r[2:0], 1'b0};
    if (r[3] ^ b) n = n ^ 4'h3;
    return n;
  endfunction

  // frame with start bit, right-aligned; returns total bit count
  function automatic int exp_frame(input logic [1:0] c, input logic [1:0] id, input logic [20:0] a,
                                   input logic [1:0] sz, input logic [31:0] wd, output logic [127:0] f);
    logic [127:0] v;
    logic [20:0]  ea;
    logic [3:0]   r;
    int n, nb;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ea = a;
    if (sz == 2'd1) ea[0] = 1'b0;
    else if (sz[1]) ea[1:0] = 2'b01;
    v = 128'(id); n = 2;
    case (c)
      2'b10: begin v = (v << 3) | 128'd2; n += 3; end
      2'b11: begin v = (v << 6) | 128'h3f; n += 6; end
      default: begin
        v = (v << 3) | 128'd4;
        v = (v << 1) | 128'(c == 2'b00);
        v = (v << 21) | 128'(ea);
        v = (v << 1) | 128'(sz != 2'd0);
        n += 26;
        if (c == 2'b01)
          for (int i = 0; i < nb; i++) begin v = (v << 8) | 128'(wd[8*i +: 8]); n += 8; end
      end
    endcase
    r = crc_upd(4'h0, 1'b1);
    for (int i = n - 1; i >= 0; i--) r = crc_upd(r, v[i]);
    v = (v << 4) | 128'(r);
    n += 4;
    f = v | (128'd1 << n);
    return n + 1;
  endfunction

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'b00:   return "R3 R4 R8 read frame";
      2'b01:   return "R5 R4 R8 write frame";
      2'b10:   return "R6 R8 poll frame";
      default: return "R7 R8 term frame";
    endcase
  endfunction

  task automatic run_frame(input logic [58:0] v, input bit poke);
    logic [127:0] exp, cap;
    int en, cn, k, viol, oe_drop;
    logic prev_l, prev_d;
    bit start_ok;
    en = exp_frame(v[58:57], v[56:55], v[54:34], v[33:32], v[31:0], exp);
    @(negedge clk_i);
    cmd_i = v[58:57]; slave_id_i = v[56:55]; addr_i = v[54:34]; size_i = v[33:32]; wdata_i = v[31:0];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    start_ok = !link_data_o && data_oe_o && trans_dir_o;
    cap = '0; cn = 0; k = 0; viol = 0; oe_drop = 0; prev_l = 1'b1; prev_d = 1'b1;
    while (!done_o && k < 2000) begin
      if (link_clk_o && !prev_l && data_oe_o) begin cap = {cap[126:0], ~link_data_o}; cn++; end
      if (data_oe_o && (link_data_o != prev_d) && link_clk_o) viol++;
      if (!data_oe_o || !trans_dir_o) oe_drop++;
      start_i = poke && (k == 20);
      if (poke && k == 20) cmd_i = ~v[58:57];
      prev_l = link_clk_o; prev_d = link_data_o;
      @(negedge clk_i);
      k++;
    end
    start_i = 1'b0;
    chk(start_ok && oe_drop == 0, "R2 start bit low and controls held", 128'(oe_drop), 128'd0);
    chk(cn == en && cap == exp, tag_of(v[58:57]), cap, exp);
    chk(k == en * 2 * HALF && viol == 0, "R9 frame cycles and data change on low half",
        128'(k), 128'(en * 2 * HALF));
    chk(done_o && link_data_o && link_clk_o && !data_oe_o && !trans_dir_o && !busy_o,
        "R10 done with line idle", {link_data_o, link_clk_o, data_oe_o, busy_o}, 128'hC);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R10 done single cycle", {done_o, busy_o}, 128'd0);
    if (poke) begin
      repeat (6) @(negedge clk_i);
      chk(!busy_o && link_data_o, "R11 no second frame after ignored start", 128'(busy_o), 128'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && link_data_o && link_clk_o && !data_oe_o && !trans_dir_o,
        "R1 lines during reset", {busy_o, done_o, link_data_o, link_clk_o, data_oe_o}, 128'h6);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && link_data_o && link_clk_o && !data_oe_o && !trans_dir_o,
        "R1 idle after reset", {busy_o, done_o, link_data_o, link_clk_o, data_oe_o}, 128'h6);
    for (int i = 0; i < NVEC; i++) run_frame(VEC[i], 1'b0);
    // R11: second start mid-frame must be ignored
    run_frame(VEC[5], 1'b1);
    run_frame(VEC[7], 1'b1);
    repeat (4) @(negedge clk_i);
    chk(!busy_o && link_data_o && link_clk_o, "R1 idle at end", {busy_o, link_data_o, link_clk_o}, 128'h3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule